// File: doc/BRIEF.md
# Floating-Point Operate Word Decoder

This block takes a 32-bit floating-point operate instruction word and turns it into the control information an execution unit needs. It recognises the two operate formats: arithmetic/conversion and compare. It names the operation class and gives a precision code for each of the two sources and for the destination. It also extracts the three register indices and checks that each register number suits the size of its operand. The arithmetic itself is done elsewhere.

The decode logic is combinational. A single register stage captures the result whenever the input strobe is high, and the outputs then stay unchanged until the next strobe. A decoded word either comes out as unimplemented, or as a recognised operation that may also carry an invalid-register fault together with its trap-type code. For compares the destination is the condition-code field, not a register.

Top module: `fpop_decoder`

## Requirements
- R1: When `in_valid` is high at a rising edge, every decoded output reflects `in_word` after that edge and `out_valid` is high for that one cycle. When `in_valid` is low, `out_valid` is low and all other outputs hold their values.
- R2: After synchronous reset every output is zero.
- R3: A word is in the arithmetic format when `(word & 0xC1F80000) == 0x81A00000` and in the compare format when the masked value is `0x81A80000`. Any other word gives `out_unimp = 1`.
- R4: The operation code is bits 13:5, and `out_rs1`, `out_rs2` and `out_rd` are bits 18:14, 4:0 and 29:25 of the word. The three indices are copied for every word.
- R5: Precision codes are 0 none, 1 single or integer, 2 double and 3 quad. In the arithmetic format, codes 0x041–0x04F with a nonzero low two-bit field are add (bits 3:2 = 0), subtract (1), multiply (2) and divide (3). For these, the low two bits give the precision of rs1, rs2 and rd.
- R6: Unary operations report rs1 precision 0. These are square root (0x029/0x02A/0x02B, precision from the low bits), conversions, and move/negate/absolute (0x001/0x005/0x009, single in and out).
- R7: Code 0x069 is multiply with single sources and a double result. Code 0x06E is multiply with double sources and a quad result.
- R8: Conversions give rs2 and rd precisions as follows: 0x0C4/0x0C8/0x0CC integer to single/double/quad; 0x0C9 single→double; 0x0CD single→quad; 0x0CE double→quad; 0x0C6 double→single; 0x0C7 quad→single; 0x0CB quad→double; 0x0D1/0x0D2/0x0D3 single/double/quad to integer. An integer operand reports precision 1 with its integer flag set.
- R9: A recognised operation faults (`out_reg_fault = 1`, `out_trap_type = 6`) if a double operand uses an odd register or a quad operand uses a register that is not a multiple of 4. Otherwise `out_trap_type = 0`.
- R10: In the compare format, 0x051/0x052/0x053 (single/double/quad) are plain compares and 0x055/0x056/0x057 are signalling compares. Both sources use the low-bit precision. The destination precision is 0, `out_rd_is_cc = 1`, and a nonzero rd field faults.
- R11: An unrecognised operation code in either format gives `out_unimp = 1` with all precisions, integer flags, class, condition-code flag, fault and trap type at zero.
- R12: `out_op_class` encodes 0 none, 1 add, 2 subtract, 3 multiply, 4 divide, 5 square root, 6 convert, 7 move, 8 negate, 9 absolute, 10 compare, 11 signalling compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Capture strobe for `in_word` |
| in_word | input | 32 | Instruction word to decode |
| out_valid | output | 1 | Decoded result captured this cycle |
| out_unimp | output | 1 | Word is not a recognised operate instruction |
| out_op_class | output | 4 | Operation class code |
| out_prec_rs1 | output | 2 | Precision of the first source |
| out_prec_rs2 | output | 2 | Precision of the second source |
| out_prec_rd | output | 2 | Precision of the destination |
| out_int_rs2 | output | 1 | Second source is an integer |
| out_int_rd | output | 1 | Destination is an integer |
| out_rs1 | output | 5 | First source register index |
| out_rs2 | output | 5 | Second source register index |
| out_rd | output | 5 | Destination register index |
| out_rd_is_cc | output | 1 | Destination is the condition-code field |
| out_reg_fault | output | 1 | Invalid-register fault |
| out_trap_type | output | 3 | Trap-type code of the fault |

## Verification
The bench sweeps all 512 operation codes in both formats, using register sets that put an odd or a not-a-multiple-of-four index in each operand slot in turn. A decoder that checked alignment on the wrong operand, or on integer operands, would show false or missing faults. Matching codes from one format inside the other would let a compare code decode as arithmetic. Mixed-width multiplies and conversions catch tables that take every width from the low code bits. Words with nonzero rd on compares and unmatched format bits catch a missing zero-rd rule or an over-wide match. Idle cycles with a changed word expose a register stage that is not gated by the strobe.

// File: rtl/fpdec_pkg.sv
package fpdec_pkg;

    localparam int WORD_W   = 32;
    localparam int OPC_W    = 9;
    localparam int REG_W    = 5;
    localparam int TRAP_W   = 3;
    localparam int NUM_OPND = 3;

    localparam logic [WORD_W-1:0] FMT_MASK    = 32'hC1F8_0000;
    localparam logic [WORD_W-1:0] FMT_ARITH   = 32'h81A0_0000;
    localparam logic [WORD_W-1:0] FMT_COMPARE = 32'h81A8_0000;
    localparam logic [TRAP_W-1:0] TRAP_BADREG = 3'd6;

    typedef enum logic [1:0] {
        PW_NONE = 2'd0,
        PW_SGL  = 2'd1,
        PW_DBL  = 2'd2,
        PW_QUAD = 2'd3
    } width_e;

    typedef enum logic [3:0] {
        OC_NONE = 4'd0,
        OC_ADD  = 4'd1,
        OC_SUB  = 4'd2,
        OC_MUL  = 4'd3,
        OC_DIV  = 4'd4,
        OC_SQRT = 4'd5,
        OC_CVT  = 4'd6,
        OC_MOV  = 4'd7,
        OC_NEG  = 4'd8,
        OC_ABS  = 4'd9,
        OC_CMP  = 4'd10,
        OC_CMPX = 4'd11
    } opclass_e;

    typedef struct packed {
        width_e width;
        logic   is_int;
    } opnd_t;

    typedef struct packed {
        logic     known;
        opclass_e cls;
        opnd_t    src1;
        opnd_t    src2;
        opnd_t    dst;
        logic     dst_cc;
    } optab_t;

    typedef struct packed {
        logic              unimp;
        opclass_e          cls;
        opnd_t             src1;
        opnd_t             src2;
        opnd_t             dst;
        logic [REG_W-1:0]  r1;
        logic [REG_W-1:0]  r2;
        logic [REG_W-1:0]  rd;
        logic              dst_cc;
        logic              fault;
        logic [TRAP_W-1:0] trap;
    } decout_t;

    function automatic opnd_t mk_opnd(width_e w, logic i);
        opnd_t o;
        o.width  = w;
        o.is_int = i;
        return o;
    endfunction

    function automatic opnd_t no_opnd();
        return mk_opnd(PW_NONE, 1'b0);
    endfunction

    function automatic logic misaligned(width_e w, logic [REG_W-1:0] idx);
        case (w)
            PW_DBL:  return idx[0];
            PW_QUAD: return |idx[1:0];
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/fpdec_optable.sv
module fpdec_optable
    import fpdec_pkg::*;
#(
    parameter int OP_W = OPC_W
) (
    input  logic            arith_sel,
    input  logic            cmp_sel,
    input  logic [OP_W-1:0] opc,
    output optab_t          info
);

    localparam logic [1:0] LOW_NONE = 2'b00;

    width_e low_w;
    assign low_w = width_e'(opc[1:0]);

    optab_t arith_info;
    optab_t cmp_info;

    always_comb begin
        arith_info        = '0;
        arith_info.src1   = no_opnd();
        arith_info.src2   = no_opnd();
        arith_info.dst    = no_opnd();
        if (opc[OP_W-1:4] == 5'b00100 && opc[1:0] != LOW_NONE) begin
            arith_info.known = 1'b1;
            case (opc[3:2])
                2'd0:    arith_info.cls = OC_ADD;
                2'd1:    arith_info.cls = OC_SUB;
                2'd2:    arith_info.cls = OC_MUL;
                default: arith_info.cls = OC_DIV;
            endcase
            arith_info.src1 = mk_opnd(low_w, 1'b0);
            arith_info.src2 = mk_opnd(low_w, 1'b0);
            arith_info.dst  = mk_opnd(low_w, 1'b0);
        end else if (opc[OP_W-1:2] == 7'b0001010 && opc[1:0] != LOW_NONE) begin
            arith_info.known = 1'b1;
            arith_info.cls   = OC_SQRT;
            arith_info.src2  = mk_opnd(low_w, 1'b0);
            arith_info.dst   = mk_opnd(low_w, 1'b0);
        end else begin
            arith_info.known = 1'b1;
            arith_info.cls   = OC_CVT;
            case (opc)
                9'h001, 9'h005, 9'h009: begin
                    arith_info.cls  = (opc[3:2] == 2'd0) ? OC_MOV :
                                      (opc[3:2] == 2'd1) ? OC_NEG : OC_ABS;
                    arith_info.src2 = mk_opnd(PW_SGL, 1'b0);
                    arith_info.dst  = mk_opnd(PW_SGL, 1'b0);
                end
                9'h069: begin
                    arith_info.cls  = OC_MUL;
                    arith_info.src1 = mk_opnd(PW_SGL, 1'b0);
                    arith_info.src2 = mk_opnd(PW_SGL, 1'b0);
                    arith_info.dst  = mk_opnd(PW_DBL, 1'b0);
                end
                9'h06E: begin
                    arith_info.cls  = OC_MUL;
                    arith_info.src1 = mk_opnd(PW_DBL, 1'b0);
                    arith_info.src2 = mk_opnd(PW_DBL, 1'b0);
                    arith_info.dst  = mk_opnd(PW_QUAD, 1'b0);
                end
                9'h0C4: begin
                    arith_info.src2 = mk_opnd(PW_SGL, 1'b1);
                    arith_info.dst  = mk_opnd(PW_SGL, 1'b0);
                end
                9'h0C8: begin
                    arith_info.src2 = mk_opnd(PW_SGL, 1'b1);
                    arith_info.dst  = mk_opnd(PW_DBL, 1'b0);
                end
                9'h0CC: begin
                    arith_info.src2 = mk_opnd(PW_SGL, 1'b1);
                    arith_info.dst  = mk_opnd(PW_QUAD, 1'b0);
                end
                9'h0C6: begin
                    arith_info.src2 = mk_opnd(PW_DBL, 1'b0);
                    arith_info.dst  = mk_opnd(PW_SGL, 1'b0);
                end
                9'h0C7: begin
                    arith_info.src2 = mk_opnd(PW_QUAD, 1'b0);
                    arith_info.dst  = mk_opnd(PW_SGL, 1'b0);
                end
                9'h0C9: begin
                    arith_info.src2 = mk_opnd(PW_SGL, 1'b0);
                    arith_info.dst  = mk_opnd(PW_DBL, 1'b0);
                end
                9'h0CB: begin
                    arith_info.src2 = mk_opnd(PW_QUAD, 1'b0);
                    arith_info.dst  = mk_opnd(PW_DBL, 1'b0);
                end
                9'h0CD: begin
                    arith_info.src2 = mk_opnd(PW_SGL, 1'b0);
                    arith_info.dst  = mk_opnd(PW_QUAD, 1'b0);
                end
                9'h0CE: begin
                    arith_info.src2 = mk_opnd(PW_DBL, 1'b0);
                    arith_info.dst  = mk_opnd(PW_QUAD, 1'b0);
                end
                9'h0D1: begin
                    arith_info.src2 = mk_opnd(PW_SGL, 1'b0);
                    arith_info.dst  = mk_opnd(PW_SGL, 1'b1);
                end
                9'h0D2: begin
                    arith_info.src2 = mk_opnd(PW_DBL, 1'b0);
                    arith_info.dst  = mk_opnd(PW_SGL, 1'b1);
                end
                9'h0D3: begin
                    arith_info.src2 = mk_opnd(PW_QUAD, 1'b0);
                    arith_info.dst  = mk_opnd(PW_SGL, 1'b1);
                end
                default: begin
                    arith_info.known = 1'b0;
                    arith_info.cls   = OC_NONE;
                end
            endcase
        end
    end

    always_comb begin
        cmp_info      = '0;
        cmp_info.src1 = no_opnd();
        cmp_info.src2 = no_opnd();
        cmp_info.dst  = no_opnd();
        if (opc[OP_W-1:3] == 6'b001010 && opc[1:0] != LOW_NONE) begin
            cmp_info.known  = 1'b1;
            cmp_info.cls    = opc[2] ? OC_CMPX : OC_CMP;
            cmp_info.src1   = mk_opnd(low_w, 1'b0);
            cmp_info.src2   = mk_opnd(low_w, 1'b0);
            cmp_info.dst_cc = 1'b1;
        end
    end

    always_comb begin
        if (arith_sel)
            info = arith_info;
        else if (cmp_sel)
            info = cmp_info;
        else begin
            info      = '0;
            info.src1 = no_opnd();
            info.src2 = no_opnd();
            info.dst  = no_opnd();
        end
    end

endmodule

// File: rtl/fpdec_regcheck.sv
module fpdec_regcheck
    import fpdec_pkg::*;
#(
    parameter int IDX_W = REG_W
) (
    input  width_e           width,
    input  logic [IDX_W-1:0] idx,
    input  logic             need_zero,
    output logic             bad
);

    always_comb begin
        if (need_zero)
            bad = |idx;
        else
            bad = misaligned(width, idx);
    end

endmodule

// File: rtl/fpdec_outreg.sv
module fpdec_outreg
    import fpdec_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    load,
    input  decout_t d,
    output decout_t q,
    output logic    q_valid
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q       <= '0;
            q_valid <= 1'b0;
        end else begin
            q_valid <= load;
            if (load)
                q <= d;
        end
    end

endmodule

// File: rtl/fpop_decoder.sv
module fpop_decoder
    import fpdec_pkg::*;
#(
    parameter int W_WORD = WORD_W,
    parameter int W_OPC  = OPC_W,
    parameter int W_REG  = REG_W,
    parameter int W_TRAP = TRAP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [W_WORD-1:0] in_word,
    output logic              out_valid,
    output logic              out_unimp,
    output logic [3:0]        out_op_class,
    output logic [1:0]        out_prec_rs1,
    output logic [1:0]        out_prec_rs2,
    output logic [1:0]        out_prec_rd,
    output logic              out_int_rs2,
    output logic              out_int_rd,
    output logic [W_REG-1:0]  out_rs1,
    output logic [W_REG-1:0]  out_rs2,
    output logic [W_REG-1:0]  out_rd,
    output logic              out_rd_is_cc,
    output logic              out_reg_fault,
    output logic [W_TRAP-1:0] out_trap_type
);

    localparam int OPC_LO = 5;
    localparam int RS1_LO = 14;
    localparam int RD_LO  = 25;

    logic              sel_arith;
    logic              sel_cmp;
    logic [W_OPC-1:0]  opc;
    logic [W_REG-1:0]  f_rs1;
    logic [W_REG-1:0]  f_rs2;
    logic [W_REG-1:0]  f_rd;
    optab_t            tab;

    assign sel_arith = (in_word & FMT_MASK) == FMT_ARITH;
    assign sel_cmp   = (in_word & FMT_MASK) == FMT_COMPARE;
    assign opc       = in_word[OPC_LO +: W_OPC];
    assign f_rs1     = in_word[RS1_LO +: W_REG];
    assign f_rs2     = in_word[0 +: W_REG];
    assign f_rd      = in_word[RD_LO +: W_REG];

    fpdec_optable #(.OP_W(W_OPC)) u_tab (
        .arith_sel (sel_arith),
        .cmp_sel   (sel_cmp),
        .opc       (opc),
        .info      (tab)
    );

    width_e           chk_w    [NUM_OPND];
    logic [W_REG-1:0] chk_idx  [NUM_OPND];
    logic             chk_zero [NUM_OPND];
    logic [NUM_OPND-1:0] chk_bad;

    always_comb begin
        chk_w[0]    = tab.src1.width;
        chk_idx[0]  = f_rs1;
        chk_zero[0] = 1'b0;
        chk_w[1]    = tab.src2.width;
        chk_idx[1]  = f_rs2;
        chk_zero[1] = 1'b0;
        chk_w[2]    = tab.dst.width;
        chk_idx[2]  = f_rd;
        chk_zero[2] = tab.dst_cc;
    end

    for (genvar g = 0; g < NUM_OPND; g++) begin : g_chk
        fpdec_regcheck #(.IDX_W(W_REG)) u_chk (
            .width     (chk_w[g]),
            .idx       (chk_idx[g]),
            .need_zero (chk_zero[g]),
            .bad       (chk_bad[g])
        );
    end

    decout_t dec_d;
    decout_t dec_q;

    always_comb begin
        dec_d        = '0;
        dec_d.unimp  = ~tab.known;
        dec_d.cls    = tab.cls;
        dec_d.src1   = tab.src1;
        dec_d.src2   = tab.src2;
        dec_d.dst    = tab.dst;
        dec_d.r1     = f_rs1;
        dec_d.r2     = f_rs2;
        dec_d.rd     = f_rd;
        dec_d.dst_cc = tab.dst_cc;
        dec_d.fault  = tab.known & (|chk_bad);
        dec_d.trap   = dec_d.fault ? TRAP_BADREG : '0;
    end

    fpdec_outreg u_oreg (
        .clk     (clk),
        .rst     (rst),
        .load    (in_valid),
        .d       (dec_d),
        .q       (dec_q),
        .q_valid (out_valid)
    );

    assign out_unimp     = dec_q.unimp;
    assign out_op_class  = dec_q.cls;
    assign out_prec_rs1  = dec_q.src1.width;
    assign out_prec_rs2  = dec_q.src2.width;
    assign out_prec_rd   = dec_q.dst.width;
    assign out_int_rs2   = dec_q.src2.is_int;
    assign out_int_rd    = dec_q.dst.is_int;
    assign out_rs1       = dec_q.r1;
    assign out_rs2       = dec_q.r2;
    assign out_rd        = dec_q.rd;
    assign out_rd_is_cc  = dec_q.dst_cc;
    assign out_reg_fault = dec_q.fault;
    assign out_trap_type = dec_q.trap;

endmodule

// File: rtl/fpdec_checker.sv
module fpdec_checker (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [31:0] in_word,
    input logic        out_valid,
    input logic        out_unimp,
    input logic [3:0]  out_op_class,
    input logic [1:0]  out_prec_rs1,
    input logic [1:0]  out_prec_rs2,
    input logic [1:0]  out_prec_rd,
    input logic        out_int_rs2,
    input logic        out_int_rd,
    input logic [4:0]  out_rs1,
    input logic [4:0]  out_rs2,
    input logic [4:0]  out_rd,
    input logic        out_rd_is_cc,
    input logic        out_reg_fault,
    input logic [2:0]  out_trap_type
);

    p_valid_follows_r1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_valid_drops_r1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    p_hold_when_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_rd) && $stable(out_op_class) && $stable(out_reg_fault)));

    p_rd_field_r4: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_rd == $past(in_word[29:25]));

    p_fault_code_r9: assert property (@(posedge clk) disable iff (rst)
        out_reg_fault |-> out_trap_type == 3'd6);

    p_no_fault_code_r9: assert property (@(posedge clk) disable iff (rst)
        !out_reg_fault |-> out_trap_type == 3'd0);

    p_cc_dest_r10: assert property (@(posedge clk) disable iff (rst)
        out_rd_is_cc |-> (out_prec_rd == 2'd0 && (out_op_class == 4'd10 || out_op_class == 4'd11)));

    p_unimp_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        out_unimp |-> (!out_reg_fault && out_prec_rs1 == 2'd0 && out_prec_rs2 == 2'd0
                       && out_prec_rd == 2'd0 && out_op_class == 4'd0 && !out_rd_is_cc));

    p_int_is_single_r8: assert property (@(posedge clk) disable iff (rst)
        (out_int_rd || out_int_rs2) |-> (out_op_class == 4'd6));

    p_unary_no_rs1_r6: assert property (@(posedge clk) disable iff (rst)
        (out_op_class >= 4'd5 && out_op_class <= 4'd9) |-> out_prec_rs1 == 2'd0);

endmodule

bind fpop_decoder fpdec_checker u_fpdec_checker (.*);

// File: tb/sim_fpop_decoder.sv
module sim_fpop_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        out_valid;
    logic        out_unimp;
    logic [3:0]  out_op_class;
    logic [1:0]  out_prec_rs1;
    logic [1:0]  out_prec_rs2;
    logic [1:0]  out_prec_rd;
    logic        out_int_rs2;
    logic        out_int_rd;
    logic [4:0]  out_rs1;
    logic [4:0]  out_rs2;
    logic [4:0]  out_rd;
    logic        out_rd_is_cc;
    logic        out_reg_fault;
    logic [2:0]  out_trap_type;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    fpop_decoder u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
        .out_valid(out_valid), .out_unimp(out_unimp), .out_op_class(out_op_class),
        .out_prec_rs1(out_prec_rs1), .out_prec_rs2(out_prec_rs2), .out_prec_rd(out_prec_rd),
        .out_int_rs2(out_int_rs2), .out_int_rd(out_int_rd),
        .out_rs1(out_rs1), .out_rs2(out_rs2), .out_rd(out_rd),
        .out_rd_is_cc(out_rd_is_cc), .out_reg_fault(out_reg_fault),
        .out_trap_type(out_trap_type)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Expected decode computed from the requirement text
    function automatic void model(input logic [31:0] w,
                                  output bit unimp, output int cls,
                                  output int p1, output int p2, output int pd,
                                  output bit i2, output bit id,
                                  output bit cc, output bit fault);
        int  op;
        bit  fmt_a;
        bit  fmt_c;
        int  lo;
        unimp = 1; cls = 0; p1 = 0; p2 = 0; pd = 0; i2 = 0; id = 0; cc = 0; fault = 0;
        op    = int'(w[13:5]);
        lo    = op % 4;
        fmt_a = (w[31:30] == 2'b10) && (w[24:19] == 6'b110100);
        fmt_c = (w[31:30] == 2'b10) && (w[24:19] == 6'b110101);
        if (fmt_a) begin
            if (op >= 'h041 && op <= 'h04F && lo != 0) begin
                unimp = 0; cls = 1 + (op - 'h040) / 4; p1 = lo; p2 = lo; pd = lo;
            end else if (op >= 'h029 && op <= 'h02B) begin
                unimp = 0; cls = 5; p2 = lo; pd = lo;
            end else if (op == 'h001 || op == 'h005 || op == 'h009) begin
                unimp = 0; cls = 7 + op / 4; p2 = 1; pd = 1;
            end else if (op == 'h069) begin
                unimp = 0; cls = 3; p1 = 1; p2 = 1; pd = 2;
            end else if (op == 'h06E) begin
                unimp = 0; cls = 3; p1 = 2; p2 = 2; pd = 3;
            end else begin
                unimp = 0; cls = 6;
                case (op)
                    'h0C4: begin p2 = 1; i2 = 1; pd = 1; end
                    'h0C8: begin p2 = 1; i2 = 1; pd = 2; end
                    'h0CC: begin p2 = 1; i2 = 1; pd = 3; end
                    'h0C9: begin p2 = 1; pd = 2; end
                    'h0CD: begin p2 = 1; pd = 3; end
                    'h0CE: begin p2 = 2; pd = 3; end
                    'h0C6: begin p2 = 2; pd = 1; end
                    'h0C7: begin p2 = 3; pd = 1; end
                    'h0CB: begin p2 = 3; pd = 2; end
                    'h0D1: begin p2 = 1; pd = 1; id = 1; end
                    'h0D2: begin p2 = 2; pd = 1; id = 1; end
                    'h0D3: begin p2 = 3; pd = 1; id = 1; end
                    default: begin unimp = 1; cls = 0; end
                endcase
            end
        end else if (fmt_c) begin
            if (op >= 'h051 && op <= 'h057 && lo != 0) begin
                unimp = 0; cls = (op >= 'h054) ? 11 : 10; p1 = lo; p2 = lo; cc = 1;
            end
        end
        if (!unimp) begin
            if ((p1 == 2 && w[14]) || (p1 == 3 && w[15:14] != 0)) fault = 1;
            if ((p2 == 2 && w[0])  || (p2 == 3 && w[1:0] != 0))   fault = 1;
            if (cc) begin
                if (w[29:25] != 0) fault = 1;
            end else if ((pd == 2 && w[25]) || (pd == 3 && w[26:25] != 0)) fault = 1;
        end
    endfunction

    task automatic check_all(input logic [31:0] w);
        bit unimp, i2, id, cc, fault;
        int cls, p1, p2, pd;
        model(w, unimp, cls, p1, p2, pd, i2, id, cc, fault);
        chk(out_unimp == unimp, "R3 R11 unimp", out_unimp, unimp);
        chk(int'(out_op_class) == cls, "R12 class", out_op_class, cls);
        chk(int'(out_prec_rs1) == p1, "R5 R6 R7 rs1 precision", out_prec_rs1, p1);
        chk(int'(out_prec_rs2) == p2, "R5 R7 R8 rs2 precision", out_prec_rs2, p2);
        chk(int'(out_prec_rd) == pd, "R5 R7 R8 rd precision", out_prec_rd, pd);
        chk({out_int_rs2, out_int_rd} == {i2, id}, "R8 integer flags", {out_int_rs2, out_int_rd}, {i2, id});
        chk({out_rs1, out_rs2, out_rd} == {w[18:14], w[4:0], w[29:25]}, "R4 register fields",
            {out_rs1, out_rs2, out_rd}, {w[18:14], w[4:0], w[29:25]});
        chk(out_rd_is_cc == cc, "R10 cc destination", out_rd_is_cc, cc);
        chk(out_reg_fault == fault, "R9 R10 register fault", out_reg_fault, fault);
        chk(out_trap_type == (fault ? 3'd6 : 3'd0), "R9 trap type", out_trap_type, fault ? 6 : 0);
    endtask

    task automatic run_one(input logic [31:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = w;
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid == 1'b1, "R1 valid pulse", out_valid, 1);
        check_all(w);
    endtask

    function automatic logic [31:0] mk_word(input logic [1:0] top, input logic [5:0] fmt,
                                             input int rd, input int rs1, input int op, input int rs2);
        return {top, 5'(rd), fmt, 5'(rs1), 9'(op), 5'(rs2)};
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : stim
        int r1s[5] = '{0, 1, 4, 8, 2};
        int r2s[5] = '{0, 4, 2, 12, 3};
        int rds[5] = '{0, 8, 0, 6, 5};
        logic [31:0] w;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R2: reset state
        chk({out_valid, out_unimp, out_op_class, out_prec_rs1, out_prec_rs2, out_prec_rd,
             out_int_rs2, out_int_rd, out_rs1, out_rs2, out_rd, out_rd_is_cc,
             out_reg_fault, out_trap_type} == '0, "R2 reset state", out_op_class, 0);

        // Exhaustive sweep of both formats with alignment patterns (R3..R12)
        for (int f = 0; f < 2; f++) begin
            for (int op = 0; op < 512; op++) begin
                for (int p = 0; p < 5; p++) begin
                    w = mk_word(2'b10, f ? 6'b110101 : 6'b110100, rds[p], r1s[p], op, r2s[p]);
                    run_one(w);
                end
            end
        end

        // R3: words outside both formats
        run_one(mk_word(2'b11, 6'b110100, 0, 0, 'h041, 0));
        run_one(mk_word(2'b10, 6'b110110, 0, 0, 'h041, 0));
        run_one(mk_word(2'b00, 6'b110101, 0, 0, 'h051, 0));
        run_one(mk_word(2'b10, 6'b010100, 0, 0, 'h042, 0));

        // R10: compare with nonzero rd faults; aligned quad compare does not
        run_one(mk_word(2'b10, 6'b110101, 1, 0, 'h053, 0));
        chk(out_reg_fault == 1'b1, "R10 nonzero rd on compare", out_reg_fault, 1);
        run_one(mk_word(2'b10, 6'b110101, 0, 4, 'h057, 8));
        chk(out_reg_fault == 1'b0, "R10 aligned signalling compare", out_reg_fault, 0);

        // R1: outputs hold while strobe is low
        w = mk_word(2'b10, 6'b110100, 4, 8, 'h04B, 12);
        run_one(w);
        in_word = mk_word(2'b10, 6'b110101, 3, 1, 'h051, 7);
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 valid low when idle", out_valid, 0);
        check_all(w);
        @(negedge clk);
        check_all(w);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule